// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block walks a fixed 640x480 true-colour picture held in word-addressed memory and produces one memory read request per visible pixel. Rows are laid out on a 1024-word pitch. Only the leading 640 words of each row are requested, and the rest of the pitch is never touched. The returned 32-bit words are split into 8-bit red, green and blue channels. Each pixel is tagged when it closes a line and when it closes the frame.

Software programs two registers. The picture base holds only the upper 11 address bits, so a frame can only be placed on a coarse boundary. The control word carries a display-on bit and a half-turn bit. When the half-turn bit is set, the scan runs backwards from the last visible word to the first, which turns the picture upside down. A frame-start strobe, standing in for the blanking interval, restarts the walk. The strobe is also the only moment at which the control bits and the base take effect, so a single frame never mixes two settings.

Top module: `fb_scan_gen`

## Requirements
- R1: After reset both registers read zero, `req_valid` and `pix_valid` are low, and the colour outputs are zero.
- R2: Register index 0 (`reg_sel`=0) is the base. It keeps only the top 11 bits of the written value, and the lower 21 bits always read back as zero.
- R3: Register index 1 (`reg_sel`=1) is the control word. Bit 0 turns the display on and bit 1 selects the half turn. All other bits read back as zero.
- R4: With the half turn off, the k-th accepted request of a frame goes to `base + (k/640)*1024 + (k%640)`.
- R5: With the half turn on, the k-th accepted request goes to `base + (479-k/640)*1024 + (639-k%640)`.
- R6: A request is consumed only on a cycle where `req_valid` and `req_ready` are both high. While it is stalled, `req_valid` stays high and `req_addr` stays unchanged.
- R7: One cycle after `rsp_valid`, the block shows the pixel: red from bits 23:16, green from bits 15:8, blue from bits 7:0. Bits 31:24 are ignored. Pixels leave in the order the words were returned.
- R8: `pix_eol` marks every 640th returned pixel. `pix_eof` marks the 307200th returned pixel of the frame, and it only ever appears together with `pix_eol`.
- R9: In a frame started with the display off, no request is issued and every response is dropped. `pix_valid` stays low and the colour outputs stay zero.
- R10: The control bits and the base are captured only at the frame-start strobe. Register writes during a frame do not change that frame.
- R11: A frame-start strobe restarts the walk from the first pixel, even in the middle of a frame. Once the last pixel has been requested, `req_valid` stays low until the next strobe.
- R12: An enabled frame issues exactly 307200 accepted requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register index: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| frame_start | input | 1 | Frame-start strobe; captures settings and restarts the walk |
| req_valid | output | 1 | Memory read request pending |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | 32 | Word address of the pending request |
| rsp_valid | input | 1 | Returned word present |
| rsp_data | input | 32 | Returned word |
| pix_valid | output | 1 | Pixel present on the colour outputs |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |
| pix_eol | output | 1 | Pixel closes a line |
| pix_eof | output | 1 | Pixel closes the frame |

## Verification
The assertions assume the memory side returns exactly one word per accepted request and never sends a response while no frame is running. The stall-hold property also assumes `frame_start` is the only thing that may pull a stalled request away. The bench's memory model answers in the same cycle it accepts a request, and it only injects unsolicited responses in the display-off scenario, where the design must drop them. Before every strobe, the bench holds `req_ready` low for two cycles, so no response is in flight when the counters restart.

// File: rtl/fb_scan_pkg.sv
`timescale 1ns/1ps
package fb_scan_pkg;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } fb_rgb_t;

  // Split the 24 colour bits of a stored word into channels.
  function automatic fb_rgb_t fb_unpack(input logic [23:0] w);
    fb_rgb_t p;
    p.red   = w[23:16];
    p.green = w[15:8];
    p.blue  = w[7:0];
    return p;
  endfunction

endpackage

// File: rtl/fb_scan_regs.sv
`timescale 1ns/1ps
module fb_scan_regs #(
  parameter int AW        = 32,
  parameter int BASE_KEEP = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 sel,
  input  logic [AW-1:0]        wdata,
  output logic [AW-1:0]        rdata,
  output logic [BASE_KEEP-1:0] base_hi,
  output logic                 ctl_on,
  output logic                 ctl_turn
);
  localparam int LOW = AW - BASE_KEEP;

  logic unused_mid;
  assign unused_mid = ^wdata[LOW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi  <= '0;
      ctl_on   <= 1'b0;
      ctl_turn <= 1'b0;
    end else if (we) begin
      if (sel) begin
        ctl_on   <= wdata[0];
        ctl_turn <= wdata[1];
      end else begin
        base_hi <= wdata[AW-1:LOW];
      end
    end
  end

  always_comb begin
    if (sel) rdata = {{(AW-2){1'b0}}, ctl_turn, ctl_on};
    else     rdata = {base_hi, {LOW{1'b0}}};
  end
endmodule

// File: rtl/fb_scan_cursor.sv
`timescale 1ns/1ps
module fb_scan_cursor #(
  parameter int H_PIX = 640,
  parameter int V_PIX = 480,
  parameter int CW    = 10,
  parameter int RW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          turn,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          last
);
  localparam logic [CW-1:0] COL_END = CW'(H_PIX - 1);
  localparam logic [RW-1:0] ROW_END = RW'(V_PIX - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (restart) begin
      col <= turn ? COL_END : '0;
      row <= turn ? ROW_END : '0;
    end else if (step) begin
      if (turn) begin
        if (col == '0) begin
          col <= COL_END;
          row <= row - 1'b1;
        end else begin
          col <= col - 1'b1;
        end
      end else begin
        if (col == COL_END) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  assign last = turn ? (col == '0 && row == '0) : (col == COL_END && row == ROW_END);
endmodule

// File: rtl/fb_scan_pixel.sv
`timescale 1ns/1ps
module fb_scan_pixel
  import fb_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic [31:0] word,
  input  logic        eol_in,
  input  logic        eof_in,
  output logic        pix_valid,
  output logic [7:0]  pix_red,
  output logic [7:0]  pix_green,
  output logic [7:0]  pix_blue,
  output logic        pix_eol,
  output logic        pix_eof
);
  fb_rgb_t px;
  logic    unused_top;

  assign px         = fb_unpack(word[23:0]);
  assign unused_top = ^word[31:24];

  always_ff @(posedge clk) begin
    if (rst || !take) begin
      pix_valid <= 1'b0;
      pix_red   <= '0;
      pix_green <= '0;
      pix_blue  <= '0;
      pix_eol   <= 1'b0;
      pix_eof   <= 1'b0;
    end else begin
      pix_valid <= 1'b1;
      pix_red   <= px.red;
      pix_green <= px.green;
      pix_blue  <= px.blue;
      pix_eol   <= eol_in;
      pix_eof   <= eof_in;
    end
  end
endmodule

// File: rtl/fb_scan_gen.sv
`timescale 1ns/1ps
module fb_scan_gen #(
  parameter int H_PIX     = 640,
  parameter int V_PIX     = 480,
  parameter int STRIDE_LG = 10,
  parameter int AW        = 32,
  parameter int BASE_KEEP = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          frame_start,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data,
  output logic          pix_valid,
  output logic [7:0]    pix_red,
  output logic [7:0]    pix_green,
  output logic [7:0]    pix_blue,
  output logic          pix_eol,
  output logic          pix_eof
);
  localparam int CW  = (H_PIX > 1) ? $clog2(H_PIX) : 1;
  localparam int RW  = (V_PIX > 1) ? $clog2(V_PIX) : 1;
  localparam int LOW = AW - BASE_KEEP;

  // Word address of memory pixel (row, col) relative to a coarse base.
  function automatic logic [AW-1:0] word_addr(input logic [BASE_KEEP-1:0] b,
                                              input logic [RW-1:0] r,
                                              input logic [CW-1:0] c);
    return {b, {LOW{1'b0}}} + (AW'(r) << STRIDE_LG) + AW'(c);
  endfunction

  logic [BASE_KEEP-1:0] cfg_base, live_base;
  logic                 cfg_on, cfg_turn;
  logic                 live_en, live_turn, scanning;
  logic                 req_fire, req_last, rsp_take;
  logic                 cur_turn;
  logic [CW-1:0]        rq_col, rs_col;
  logic [RW-1:0]        rq_row, rs_row;
  logic                 rs_last;
  logic                 line_end, frame_end;

  fb_scan_regs #(.AW(AW), .BASE_KEEP(BASE_KEEP)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .base_hi(cfg_base), .ctl_on(cfg_on), .ctl_turn(cfg_turn)
  );

  // Settings take effect only at the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_en   <= 1'b0;
      live_turn <= 1'b0;
      live_base <= '0;
      scanning  <= 1'b0;
    end else if (frame_start) begin
      live_en   <= cfg_on;
      live_turn <= cfg_turn;
      live_base <= cfg_base;
      scanning  <= cfg_on;
    end else if (req_fire && req_last) begin
      scanning  <= 1'b0;
    end
  end

  assign req_valid = scanning;
  assign req_fire  = req_valid && req_ready;
  assign cur_turn  = frame_start ? cfg_turn : live_turn;
  assign req_addr  = word_addr(live_base, rq_row, rq_col);

  fb_scan_cursor #(.H_PIX(H_PIX), .V_PIX(V_PIX), .CW(CW), .RW(RW)) u_req_cur (
    .clk(clk), .rst(rst), .restart(frame_start), .turn(cur_turn),
    .step(req_fire), .col(rq_col), .row(rq_row), .last(req_last)
  );

  // Screen-order position of returned words, for line and frame tags.
  assign rsp_take = rsp_valid && live_en;

  fb_scan_cursor #(.H_PIX(H_PIX), .V_PIX(V_PIX), .CW(CW), .RW(RW)) u_rsp_cur (
    .clk(clk), .rst(rst), .restart(frame_start), .turn(1'b0),
    .step(rsp_take), .col(rs_col), .row(rs_row), .last(rs_last)
  );

  assign line_end  = (rs_col == CW'(H_PIX - 1));
  assign frame_end = rs_last;

  fb_scan_pixel u_pix (
    .clk(clk), .rst(rst), .take(rsp_take), .word(rsp_data),
    .eol_in(line_end), .eof_in(frame_end),
    .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
    .pix_blue(pix_blue), .pix_eol(pix_eol), .pix_eof(pix_eof)
  );
endmodule

// File: rtl/fb_scan_gen_chk.sv
`timescale 1ns/1ps
module fb_scan_gen_chk #(
  parameter int H_PIX     = 640,
  parameter int V_PIX     = 480,
  parameter int AW        = 32,
  parameter int BASE_KEEP = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          reg_sel,
  input logic [AW-1:0] reg_rdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          live_en,
  input logic          pix_valid,
  input logic [7:0]    pix_red,
  input logic [7:0]    pix_green,
  input logic [7:0]    pix_blue,
  input logic          pix_eol,
  input logic          pix_eof
);
  localparam int LOW = AW - BASE_KEEP;
  localparam logic [31:0] TOTAL = 32'(H_PIX * V_PIX);

  logic [31:0] fire_cnt;
  always_ff @(posedge clk) begin
    if (rst || frame_start) fire_cnt <= '0;
    else if (req_valid && req_ready) fire_cnt <= fire_cnt + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !pix_valid));

  assert_base_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_sel |-> (reg_rdata[LOW-1:0] == '0));

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    reg_sel |-> (reg_rdata[AW-1:2] == '0));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !frame_start) |=> (req_valid && $stable(req_addr)));

  assert_eof_with_eol_R8: assert property (@(posedge clk) disable iff (rst)
    pix_eof |-> (pix_eol && pix_valid));

  assert_off_no_request_R9: assert property (@(posedge clk) disable iff (rst)
    !live_en |-> !req_valid);

  assert_idle_black_R9: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> (pix_red == 8'd0 && pix_green == 8'd0 && pix_blue == 8'd0 && !pix_eol));

  assert_request_budget_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !frame_start) |-> (fire_cnt < TOTAL));
endmodule

bind fb_scan_gen fb_scan_gen_chk #(
  .H_PIX(H_PIX), .V_PIX(V_PIX), .AW(AW), .BASE_KEEP(BASE_KEEP)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .live_en(live_en), .pix_valid(pix_valid),
  .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
  .pix_eol(pix_eol), .pix_eof(pix_eof)
);

// File: tb/fb_scan_gen_test.sv
`timescale 1ns/1ps
module fb_scan_gen_test;
  localparam int H = 6;
  localparam int V = 4;
  localparam int SL = 3;
  localparam int TOTAL = H * V;
  localparam logic [31:0] MASK = 32'hFFE0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        frame_start = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        pix_valid, pix_eol, pix_eof;
  logic [7:0]  pix_red, pix_green, pix_blue;

  fb_scan_gen #(.H_PIX(H), .V_PIX(V), .STRIDE_LG(SL), .AW(32), .BASE_KEEP(11)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frame_start(frame_start), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pix_valid(pix_valid), .pix_red(pix_red),
    .pix_green(pix_green), .pix_blue(pix_blue), .pix_eol(pix_eol), .pix_eof(pix_eof)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int req_n = 0, pix_n = 0, eof_cnt = 0, cyc = 0;
  int ready_mode = 2;
  bit force_rsp = 1'b0;
  bit exp_en = 1'b0, exp_rot = 1'b0;
  logic [31:0] exp_base = '0, sh_base = '0;
  logic [1:0]  sh_ctrl = '0;
  logic [7:0]  lfsr = 8'h5B;
  bit prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int idx);
    int r, c;
    r = idx / H;
    c = idx % H;
    if (exp_rot) begin
      r = V - 1 - r;
      c = H - 1 - c;
    end
    return (exp_base & MASK) + 32'(r * (1 << SL)) + 32'(c);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + a[28:21] + 8'd11, a[7:0] ^ 8'h96, ~a[7:0]};
  endfunction

  // Memory model and scoreboard, acting at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (pix_valid) begin
          logic [31:0] w;
          w = mem_word(exp_addr(pix_n));
          check(exp_en, "R9 pixel while off", 32'(pix_valid), 32'd0);
          check({pix_red, pix_green, pix_blue} == w[23:0], "R7 colour", {8'd0, pix_red, pix_green, pix_blue}, {8'd0, w[23:0]});
          check(pix_eol == ((pix_n % H) == H - 1), "R8 eol", 32'(pix_eol), 32'((pix_n % H) == H - 1));
          check(pix_eof == (pix_n == TOTAL - 1), "R8 eof", 32'(pix_eof), 32'(pix_n == TOTAL - 1));
          if (pix_eof) eof_cnt++;
          pix_n++;
        end else if (force_rsp) begin
          check({pix_red, pix_green, pix_blue} == 24'd0, "R9 black", {8'd0, pix_red, pix_green, pix_blue}, 32'd0);
        end
        if (prev_stall && !frame_start)
          check(req_valid && req_addr == prev_addr, "R6 stall hold", req_addr, prev_addr);
        begin
          bit rdy, fire;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          case (ready_mode)
            0: rdy = 1'b1;
            1: rdy = cyc[0];
            3: rdy = lfsr[0];
            default: rdy = 1'b0;
          endcase
          req_ready = rdy;
          fire = req_valid && rdy;
          if (fire) begin
            check(exp_en, "R9 request while off", 32'd1, 32'd0);
            check(req_n < TOTAL, "R12 request count", 32'(req_n), 32'(TOTAL));
            check(req_addr == exp_addr(req_n), exp_rot ? "R5 address" : "R4 address", req_addr, exp_addr(req_n));
            req_n++;
          end
          prev_stall = req_valid && !rdy;
          prev_addr  = req_addr;
          rsp_valid  = fire || force_rsp;
          rsp_data   = force_rsp ? 32'hFFFF_FFFF : mem_word(req_addr);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic write_reg(input bit sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 1'b0;
    if (sel) sh_ctrl = d[1:0]; else sh_base = d;
  endtask

  task automatic start_frame();
    ready_mode = 2;
    tick(); tick();
    exp_en = sh_ctrl[0]; exp_rot = sh_ctrl[1]; exp_base = sh_base;
    req_n = 0; pix_n = 0; eof_cnt = 0;
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
  endtask

  task automatic finish_frame(input string tag);
    int n = 0;
    while (eof_cnt == 0 && n < 3000) begin tick(); n++; end
    repeat (8) tick();
    check(eof_cnt == 1, "R8 one eof", 32'(eof_cnt), 32'd1);
    check(req_n == TOTAL, "R12 total requests", 32'(req_n), 32'(TOTAL));
    check(pix_n == TOTAL, "R7 pixel count", 32'(pix_n), 32'(TOTAL));
    check(!req_valid, "R11 quiet after frame", 32'(req_valid), 32'd0);
    $display("scenario %s done", tag);
  endtask

  task automatic t_reset();
    reg_sel = 1'b0; #1;
    check(reg_rdata == 0, "R1 base reset", reg_rdata, 0);
    reg_sel = 1'b1; #1;
    check(reg_rdata == 0, "R1 ctrl reset", reg_rdata, 0);
    check(!req_valid && !pix_valid, "R1 outputs idle", {30'd0, req_valid, pix_valid}, 0);
    check({pix_red, pix_green, pix_blue} == 0, "R1 black", {8'd0, pix_red, pix_green, pix_blue}, 0);
  endtask

  task automatic t_registers();
    write_reg(1'b0, 32'hFFFF_FFFF);
    reg_sel = 1'b0; #1;
    check(reg_rdata == 32'hFFE0_0000, "R2 base readback", reg_rdata, 32'hFFE0_0000);
    write_reg(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #1;
    check(reg_rdata == 32'd3, "R3 ctrl readback", reg_rdata, 32'd3);
    write_reg(1'b1, 32'd0);
    reg_sel = 1'b1; #1;
    check(reg_rdata == 32'd0, "R3 ctrl cleared", reg_rdata, 0);
  endtask

  task automatic t_plain();
    write_reg(1'b0, 32'h0040_1234);
    write_reg(1'b1, 32'd1);
    start_frame();
    ready_mode = 0;
    finish_frame("R4 plain");
  endtask

  task automatic t_rotated();
    write_reg(1'b0, 32'h0060_0000);
    write_reg(1'b1, 32'd3);
    start_frame();
    ready_mode = 3;
    finish_frame("R5 rotated");
  endtask

  task automatic t_disabled();
    int n0;
    write_reg(1'b1, 32'd2);
    start_frame();
    ready_mode = 0;
    force_rsp = 1'b1;
    n0 = 0;
    repeat (40) begin tick(); if (pix_valid) n0++; end
    force_rsp = 1'b0;
    tick();
    check(req_n == 0, "R9 no requests", 32'(req_n), 0);
    check(n0 == 0, "R9 no pixels", 32'(n0), 0);
  endtask

  task automatic t_midframe_write();
    write_reg(1'b0, 32'h0020_0000);
    write_reg(1'b1, 32'd1);
    start_frame();
    ready_mode = 1;
    repeat (6) tick();
    write_reg(1'b1, 32'd3);
    write_reg(1'b0, 32'h00A0_0000);
    finish_frame("R10 mid-frame write");
    start_frame();
    ready_mode = 0;
    finish_frame("R10 next frame");
  endtask

  task automatic t_restart();
    write_reg(1'b1, 32'd1);
    start_frame();
    ready_mode = 1;
    repeat (15) tick();
    check(req_n > 0 && req_n < TOTAL, "R11 partial frame", 32'(req_n), 32'(TOTAL));
    start_frame();
    ready_mode = 0;
    finish_frame("R11 restart");
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (5) tick();
    t_reset();
    rst = 1'b0;
    repeat (4) tick();
    t_reset();
    t_registers();
    t_plain();
    t_rotated();
    t_disabled();
    t_midframe_write();
    t_restart();
    finish_up();
  end
endmodule